// File: doc/BRIEF.md
# Synchronous Character Transmitter with Idle Fill

This block turns a stream of host characters into a continuous synchronous serial line. When a start pulse arrives with the block idle, it first sends a fixed run of seven synchronizing characters (code 0x16). It then sends host characters back to back. If the host has nothing ready at a character boundary, the block sends another synchronizing character, so the line never pauses at the synchronous rate. Bits leave least significant first, one per pulse of a bit-enable strobe supplied by a rate generator outside the block.

Host characters enter through a valid/ready handshake with back-pressure. `in_ready` rises for exactly one clock: the cycle in which the strobe shifts out the final bit of the character on the line. A character moves only when `in_valid` and `in_ready` are both high in that cycle. At all other times the host must hold `in_valid` and `in_data` steady. When `in_valid` is low at that moment, the block does not wait: it sends a fill character and pulses `fill_pulse`. A longer synchronizing run than the built-in seven is sent by the host as ordinary data characters of value 0x16.

When `ascii7_mode` is high, bit 7 of every character the block sends is replaced by a parity bit over bits 6..0. This applies to host characters and to synchronizing characters alike. The parity is odd when `parity_odd` is 1 and even when it is 0, so that the later 7-bit line conversion yields correct parity. A stop pulse lets the current character finish and then returns the line to mark.

Top module: `sync_tx_fill`

## Requirements
- R1: After reset, `line_out` is 1 and `in_ready`, `fill_pulse`, `preamble_busy` and `active` are all 0.
- R2: A `start` pulse while idle sends seven characters of code 0x16, least significant bit first, one bit per `bit_en` strobe. `preamble_busy` is high throughout those seven characters and low afterwards.
- R3: During the preamble, `in_ready` stays low. The one exception is the final bit of the seventh synchronizing character, where the first host character may be taken.
- R4: Host characters taken at successive boundaries appear on the line back to back, with no idle bits between them.
- R5: `in_ready` is high only in a cycle with `bit_en` high on the last bit of a character, and never on the boundary where a stop takes effect. A character is consumed only when `in_valid` is also high in that cycle.
- R6: If `in_valid` is low while `in_ready` is high, the next character sent is 0x16 and `fill_pulse` is high in that same cycle.
- R7: A host character of value 0x16 is sent as ordinary data. It is not dropped or merged, and `fill_pulse` stays low when it is taken.
- R8: With `ascii7_mode` high, every sent character has bits 6..0 of its source, with bit 7 set so that the number of ones in all 8 bits is odd if `parity_odd` is 1 and even if it is 0. The configuration is sampled when the character is loaded. With `ascii7_mode` low, characters are sent unchanged.
- R9: A `stop` pulse while active lets the character in flight finish. On its last bit no character is taken. After that, `active` is 0 and `line_out` stays 1.
- R10: A `start` pulse while active does not restart the preamble, and a `stop` pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit |
| start | input | 1 | Begin a transmission (idle only) |
| stop | input | 1 | End after the current character |
| ascii7_mode | input | 1 | Replace bit 7 with line parity |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| in_valid | input | 1 | Host character available |
| in_data | input | 8 | Host character |
| in_ready | output | 1 | Character taken this cycle if valid |
| line_out | output | 1 | Serial line, mark = 1 |
| preamble_busy | output | 1 | Synchronizing preamble in progress |
| fill_pulse | output | 1 | A fill character is being loaded |
| active | output | 1 | Transmission in progress |

## Verification
The first bit of a new transmission appears on `line_out` in the cycle after the `start` edge. After that, each bit changes only on a clock edge where `bit_en` is high. `in_ready` and `fill_pulse` are combinational in the boundary cycle itself. The bench therefore raises `bit_en` at a falling edge, waits a short delay, and reads the line bit and the handshake outputs before the rising edge that consumes them. The next character's first bit is due one edge after that boundary, and `active` falls on the same edge as the final boundary after a stop. Mark level is then checked on the following strobes.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] SYN_CODE = 8'h16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/sync_tx_parity.sv
module sync_tx_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] raw_char,
  input  logic         ascii7_mode,
  input  logic         parity_odd,
  output logic [W-1:0] line_char
);
  logic par_bit;

  always_comb begin
    par_bit = (^raw_char[W-2:0]) ^ parity_odd;
    if (ascii7_mode) line_char = {par_bit, raw_char[W-2:0]};
    else             line_char = raw_char;
  end
endmodule

// File: rtl/sync_tx_shifter.sv
module sync_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_char,
  input  logic         shift_en,
  input  logic         clear,
  output logic         ser_bit,
  output logic         last_bit
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '1;
      cnt  <= '0;
    end else if (load) begin
      sreg <= load_char;
      cnt  <= '0;
    end else if (clear) begin
      sreg <= '1;
      cnt  <= '0;
    end else if (shift_en) begin
      sreg <= {1'b1, sreg[W-1:1]};
      cnt  <= cnt + 1'b1;
    end
  end

  assign ser_bit  = sreg[0];
  assign last_bit = (cnt == LAST_IDX);

  assert_load_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == '0));
endmodule

// File: rtl/sync_tx_seq.sv
module sync_tx_seq
  import sync_tx_pkg::*;
#(
  parameter int W       = 8,
  parameter int PRE_LEN = 7,
  parameter logic [W-1:0] SYN = 8'h16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         start,
  input  logic         stop,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         last_bit,
  input  logic         ascii7_mode,
  input  logic         parity_odd,
  input  logic [W-1:0] line_char,
  output logic [W-1:0] raw_char,
  output logic         load,
  output logic         shift_en,
  output logic         clear,
  output logic         in_ready,
  output logic         fill_pulse,
  output logic         preamble_busy,
  output logic         active
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [PW-1:0] PRE_MAX = PW'(PRE_LEN);

  tx_state_t     state;
  logic [PW-1:0] pre_cnt;
  logic          stop_pend;
  logic          boundary, start_go, stop_now, pre_more, take;

  always_comb begin
    boundary = bit_en && last_bit && (state != ST_IDLE);
    start_go = (state == ST_IDLE) && start;
    stop_now = boundary && (stop_pend || stop);
    pre_more = (state == ST_PRE) && (pre_cnt < PRE_MAX);
    in_ready = boundary && !stop_now && !pre_more;
    take     = in_ready && in_valid;
    fill_pulse = in_ready && !in_valid;
    load     = start_go || (boundary && !stop_now);
    clear    = stop_now;
    shift_en = bit_en && (state != ST_IDLE) && !last_bit;
    raw_char = take ? in_data : SYN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pre_cnt   <= '0;
      stop_pend <= 1'b0;
    end else begin
      if (start_go) begin
        state   <= ST_PRE;
        pre_cnt <= PW'(1);
      end else if (boundary) begin
        if (stop_now) begin
          state   <= ST_IDLE;
          pre_cnt <= '0;
        end else if (pre_more) begin
          pre_cnt <= pre_cnt + 1'b1;
        end else begin
          state <= ST_RUN;
        end
      end

      if (stop_now || state == ST_IDLE) stop_pend <= 1'b0;
      else if (stop)                    stop_pend <= 1'b1;
    end
  end

  assign preamble_busy = (state == ST_PRE);
  assign active        = (state != ST_IDLE);

  assert_preamble_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    preamble_busy |-> (pre_cnt != '0 && pre_cnt <= PRE_MAX));
  assert_ready_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && last_bit));
  assert_fill_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pulse |-> (!in_valid && line_char[W-2:0] == SYN[W-2:0]));
  assert_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ascii7_mode) |-> ((^line_char) == parity_odd));
endmodule

// File: rtl/sync_tx_fill.sv
module sync_tx_fill
  import sync_tx_pkg::*;
#(
  parameter int W       = CHAR_W,
  parameter int PRE_LEN = 7,
  parameter logic [W-1:0] SYN = SYN_CODE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         start,
  input  logic         stop,
  input  logic         ascii7_mode,
  input  logic         parity_odd,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         line_out,
  output logic         preamble_busy,
  output logic         fill_pulse,
  output logic         active
);
  logic [W-1:0] raw_char, line_char;
  logic         load, shift_en, clear, last_bit, ser_bit;

  sync_tx_parity #(.W(W)) u_parity (
    .raw_char    (raw_char),
    .ascii7_mode (ascii7_mode),
    .parity_odd  (parity_odd),
    .line_char   (line_char)
  );

  sync_tx_seq #(.W(W), .PRE_LEN(PRE_LEN), .SYN(SYN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .start         (start),
    .stop          (stop),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .last_bit      (last_bit),
    .ascii7_mode   (ascii7_mode),
    .parity_odd    (parity_odd),
    .line_char     (line_char),
    .raw_char      (raw_char),
    .load          (load),
    .shift_en      (shift_en),
    .clear         (clear),
    .in_ready      (in_ready),
    .fill_pulse    (fill_pulse),
    .preamble_busy (preamble_busy),
    .active        (active)
  );

  sync_tx_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_char (line_char),
    .shift_en  (shift_en),
    .clear     (clear),
    .ser_bit   (ser_bit),
    .last_bit  (last_bit)
  );

  assign line_out = ser_bit;

  assert_idle_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(start)) |-> line_out);
endmodule

// File: tb/test_sync_tx_fill.sv
module test_sync_tx_fill;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, start = 1'b0, stop = 1'b0;
  logic       ascii7_mode = 1'b0, parity_odd = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, line_out, preamble_busy, fill_pulse, active;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sync_tx_fill i_sync_tx_fill (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start), .stop(stop),
    .ascii7_mode(ascii7_mode), .parity_odd(parity_odd),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .line_out(line_out), .preamble_busy(preamble_busy),
    .fill_pulse(fill_pulse), .active(active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(output logic b, output logic rdy, output logic fl, output logic pb);
    @(negedge clk);
    bit_en = 1'b1;
    #1;
    b = line_out; rdy = in_ready; fl = fill_pulse; pb = preamble_busy;
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_char(output logic [7:0] c, output logic rdy_mid,
                           output logic rdy_last, output logic fl_last,
                           output logic pb_first);
    logic b, r, f, p;
    rdy_mid = 1'b0; rdy_last = 1'b0; fl_last = 1'b0; pb_first = 1'b0;
    for (int i = 0; i < 8; i++) begin
      strobe(b, r, f, p);
      c[i] = b;
      if (i == 0) pb_first = p;
      if (i < 7) rdy_mid = rdy_mid | r | f;
      else begin rdy_last = r; fl_last = f; end
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic t_reset;
    chk(line_out === 1'b1, "R1 line", line_out, 1);
    chk({in_ready, fill_pulse, preamble_busy, active} === 4'b0, "R1 flags",
        {in_ready, fill_pulse, preamble_busy, active}, 0);
  endtask

  task automatic t_stream;
    logic [7:0] c; logic rm, rl, fl, pb;
    ascii7_mode = 1'b0;
    in_valid = 1'b1; in_data = 8'h55;
    pulse(start);
    for (int k = 0; k < 7; k++) begin
      read_char(c, rm, rl, fl, pb);
      chk(c == 8'h16, "R2 preamble char", c, 8'h16);
      chk(pb == 1'b1, "R2 preamble_busy", pb, 1);
      chk(rm == 1'b0, "R3 no mid accept", rm, 0);
      chk(rl == (k == 6), "R3 accept only after seventh", rl, (k == 6));
    end
    in_data = 8'hA3;
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h55, "R4 first data", c, 8'h55);
    chk(pb == 1'b0, "R2 busy low after preamble", pb, 0);
    chk(rl && !fl && !rm, "R5 ready at last bit", {rm, rl, fl}, 3'b010);
    in_data = 8'h16;
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'hA3, "R8 eight-bit unchanged / R4 back to back", c, 8'hA3);
    in_valid = 1'b0;
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h16, "R7 host syn sent", c, 8'h16);
    chk(rl && fl, "R6 fill pulse on underrun", {rl, fl}, 2'b11);
    in_valid = 1'b1; in_data = 8'h3C;
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h16, "R6 fill char", c, 8'h16);
    chk(!fl, "R7 no fill for host data", fl, 0);
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h3C, "R4 data after fill", c, 8'h3C);
  endtask

  task automatic t_restart;
    logic [7:0] c; logic rm, rl, fl, pb;
    in_data = 8'h5A;
    pulse(start);
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h3C && !pb, "R10 start while active ignored", c, 8'h3C);
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h5A && !pb, "R10 no new preamble", c, 8'h5A);
  endtask

  task automatic t_stop;
    logic [7:0] c; logic rm, rl, fl, pb, b, r, f, p;
    in_data = 8'h77;
    pulse(stop);
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h5A, "R9 current char completes", c, 8'h5A);
    chk(!rl && !fl, "R9 no accept at stop", {rl, fl}, 0);
    chk(active == 1'b0, "R9 inactive", active, 0);
    for (int i = 0; i < 10; i++) begin
      strobe(b, r, f, p);
      chk(b == 1'b1 && !r, "R9 idle mark", b, 1);
    end
  endtask

  task automatic t_parity;
    logic [7:0] c; logic rm, rl, fl, pb, b, r, f, p;
    pulse(stop);
    strobe(b, r, f, p);
    chk(b == 1'b1 && active == 1'b0, "R10 stop while idle", {active, b}, 1);
    ascii7_mode = 1'b1; parity_odd = 1'b0;
    in_valid = 1'b1; in_data = 8'h43;
    pulse(start);
    for (int k = 0; k < 7; k++) begin
      read_char(c, rm, rl, fl, pb);
      chk(c == 8'h96, "R8 even parity syn", c, 8'h96);
    end
    in_data = 8'h41;
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'hC3, "R8 even parity data", c, 8'hC3);
    parity_odd = 1'b1; in_data = 8'h43;
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h41, "R8 even parity bit7 clear", c, 8'h41);
    in_valid = 1'b0;
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h43, "R8 odd parity data", c, 8'h43);
    pulse(stop);
    read_char(c, rm, rl, fl, pb);
    chk(c == 8'h16, "R8 odd parity fill", c, 8'h16);
    chk(active == 1'b0, "R9 stopped", active, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_restart();
    t_stop();
    t_parity();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule